// File: doc/BRIEF.md
# Block-Boundary Activity Gate

This block scores how strongly a compressed-video block edge shows up around one pixel. Four boundaries are examined: above, below, left and right. Each boundary has four pixels on the near side and four facing pixels across the edge. For each boundary the block subtracts every facing pixel from its near-side partner and adds the four signed differences. It then takes the absolute value of that sum. Because the differences are summed before the absolute value, only a common DC step across the edge produces a large score. Texture whose differences change sign cancels out. The block does not assume any block size or grid position. It works only on the 32 pixels it is given.

The four boundary scores are added into one activity total. The total is compared with a threshold that software loads. The one-bit result selects the range weight for a downstream edge-preserving smoothing filter. One input set is accepted per cycle, and results appear after a fixed pipeline delay.

Top module: `blk_activity_gate`

## Requirements
- R1: Each boundary score is the absolute value of the signed sum of its four differences (near minus facing). Differences of opposite sign cancel, and a uniform negative step scores the same as a uniform positive one.
- R2: `activity` is the unsigned sum of the four boundary scores. Lane `s*4+j` of `inner_px`/`outer_px` (pixel bits `[8*lane +: 8]`) is tap `j` of boundary `s`, with s = 0 above, 1 below, 2 left, 3 right.
- R3: `gate` is 0 when `activity` is strictly below the threshold, and 1 when it is equal to or above it.
- R4: `out_valid` is high exactly two clock cycles after each cycle with `in_valid` high. A new input can be accepted on every cycle.
- R5: A threshold write (`lam_we` high) applies to inputs accepted on later cycles. An input accepted in the same cycle as the write is judged against the previous threshold.
- R6: After reset, `out_valid`, `gate` and `activity` are 0 and the threshold equals the parameter `LAM_RST` (default 64).
- R7: While `out_valid` is low, `gate` and `activity` keep their last values. Pixels presented with `in_valid` low have no effect.
- R8: At full scale there is no overflow. All near pixels at 255 with all facing pixels at 0, or the reverse, give `activity` 4080.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Pixel set on the buses is accepted this cycle |
| inner_px | input | 128 | 16 near-side pixels, 8 bits each, lane order per R2 |
| outer_px | input | 128 | 16 facing pixels across each boundary, same lane order |
| lam_we | input | 1 | Load `lam_wdata` into the threshold register |
| lam_wdata | input | 13 | New threshold value |
| out_valid | output | 1 | `gate` and `activity` hold a new result |
| gate | output | 1 | Range-weight select: 1 when activity reaches the threshold |
| activity | output | 13 | Total boundary activity |

## Verification
The embedded properties check, on every cycle, the two-stage travel of the valid flag. They also check that the results hold steady when no result arrives, and that no boundary score or total ever exceeds its full-scale bound. Several behaviours can only be shown by the bench's scenarios. These are the arithmetic itself: sign cancellation inside a boundary, the sum across boundaries, and the exact-equality edge of the compare. They also include the cycle on which a threshold write starts to count relative to an input in the same cycle, and the fact that pixels offered without a valid strobe are ignored.

// File: rtl/bact_pkg.sv
package bact_pkg;
   // number of block edges examined around the centre pixel
   localparam int unsigned SIDE_COUNT = 4;

   // largest legal total for a given geometry
   function automatic int unsigned act_bound(input int unsigned pix_w,
                                             input int unsigned taps,
                                             input int unsigned sides);
      return sides * taps * ((1 << pix_w) - 1);
   endfunction
endpackage

// File: rtl/bact_side_meas.sv
module bact_side_meas #(
   parameter int unsigned PIX_W = 8,
   parameter int unsigned TAPS  = 4
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic                                    load,
   input  logic [TAPS*PIX_W-1:0]                   near_px,
   input  logic [TAPS*PIX_W-1:0]                   far_px,
   output logic [PIX_W+$clog2(TAPS)-1:0]           mag_q
);
   localparam int unsigned DIFF_W = PIX_W + 1;
   localparam int unsigned SUM_W  = DIFF_W + $clog2(TAPS);
   localparam int unsigned MAG_W  = SUM_W - 1;

   logic signed [DIFF_W-1:0] diff_w [TAPS];
   logic signed [SUM_W-1:0]  acc_w;
   logic        [MAG_W-1:0]  abs_w;

   for (genvar j = 0; j < TAPS; j++) begin : g_tap
      assign diff_w[j] = $signed({1'b0, near_px[j*PIX_W +: PIX_W]})
                       - $signed({1'b0, far_px[j*PIX_W +: PIX_W]});
   end

   always_comb begin
      acc_w = '0;
      for (int j = 0; j < TAPS; j++) begin
         acc_w = acc_w + SUM_W'(diff_w[j]);
      end
   end

   assign abs_w = acc_w[SUM_W-1] ? MAG_W'(-acc_w) : MAG_W'(acc_w);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mag_q <= '0;
      end else if (load) begin
         mag_q <= abs_w;
      end
   end

   // R8
   side_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(mag_q) <= bact_pkg::act_bound(PIX_W, TAPS, 1))
      else $error("boundary score above full scale");
endmodule

// File: rtl/bact_total_cmp.sv
module bact_total_cmp #(
   parameter int unsigned PIX_W = 8,
   parameter int unsigned TAPS  = 4,
   parameter int unsigned SIDES = 4,
   parameter int unsigned MAG_W = 10,
   parameter int unsigned TOT_W = 13
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load,
   input  logic [SIDES*MAG_W-1:0] mags,
   input  logic [TOT_W-1:0]       lam,
   output logic                   out_valid,
   output logic                   gate,
   output logic [TOT_W-1:0]       activity
);
   logic [TOT_W-1:0] sum_w;

   always_comb begin
      sum_w = '0;
      for (int s = 0; s < SIDES; s++) begin
         sum_w = sum_w + TOT_W'(mags[s*MAG_W +: MAG_W]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         gate      <= 1'b0;
         activity  <= '0;
      end else begin
         out_valid <= load;
         if (load) begin
            activity <= sum_w;
            gate     <= (sum_w >= lam);
         end
      end
   end

   // R4
   out_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> out_valid)
      else $error("result missing after stage one");

   // R4
   out_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> !out_valid)
      else $error("spurious result strobe");

   // R7
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(activity) && $stable(gate)))
      else $error("result changed without a new input");

   // R8
   total_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(activity) <= bact_pkg::act_bound(PIX_W, TAPS, SIDES))
      else $error("total above full scale");
endmodule

// File: rtl/blk_activity_gate.sv
module blk_activity_gate #(
   parameter int unsigned PIX_W   = 8,
   parameter int unsigned TAPS    = 4,
   parameter int unsigned SIDES   = 4,
   parameter int unsigned LAM_RST = 64,
   localparam int unsigned NPIX   = SIDES * TAPS,
   localparam int unsigned TOT_W  = PIX_W + 1 + $clog2(TAPS) + $clog2(SIDES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic [NPIX*PIX_W-1:0] inner_px,
   input  logic [NPIX*PIX_W-1:0] outer_px,
   input  logic                  lam_we,
   input  logic [TOT_W-1:0]      lam_wdata,
   output logic                  out_valid,
   output logic                  gate,
   output logic [TOT_W-1:0]      activity
);
   localparam int unsigned MAG_W  = PIX_W + $clog2(TAPS);
   localparam int unsigned SIDE_B = TAPS * PIX_W;

   // elaboration-time parameter checks
   if (PIX_W < 1 || PIX_W > 16) begin : g_bad_pix
      $error("PIX_W out of supported range");
   end
   if (TAPS < 2) begin : g_bad_taps
      $error("TAPS must be at least 2");
   end
   if (SIDES != bact_pkg::SIDE_COUNT) begin : g_bad_sides
      $error("SIDES must match the four block edges");
   end
   if (LAM_RST >= (1 << TOT_W)) begin : g_bad_lam
      $error("LAM_RST does not fit the threshold width");
   end

   logic [TOT_W-1:0]       lam_q;
   logic [TOT_W-1:0]       s1_lam;
   logic                   s1_valid;
   logic [SIDES*MAG_W-1:0] mag_bus;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lam_q    <= TOT_W'(LAM_RST);
         s1_lam   <= TOT_W'(LAM_RST);
         s1_valid <= 1'b0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_lam <= lam_q;
         end
         if (lam_we) begin
            lam_q <= lam_wdata;
         end
      end
   end

   for (genvar s = 0; s < SIDES; s++) begin : g_side
      bact_side_meas #(.PIX_W(PIX_W), .TAPS(TAPS)) i_meas (
         .clk     (clk),
         .rst_n   (rst_n),
         .load    (in_valid),
         .near_px (inner_px[s*SIDE_B +: SIDE_B]),
         .far_px  (outer_px[s*SIDE_B +: SIDE_B]),
         .mag_q   (mag_bus[s*MAG_W +: MAG_W])
      );
   end

   bact_total_cmp #(
      .PIX_W (PIX_W),
      .TAPS  (TAPS),
      .SIDES (SIDES),
      .MAG_W (MAG_W),
      .TOT_W (TOT_W)
   ) i_total (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (s1_valid),
      .mags      (mag_bus),
      .lam       (s1_lam),
      .out_valid (out_valid),
      .gate      (gate),
      .activity  (activity)
   );

   // R4
   stage_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> s1_valid)
      else $error("accepted input lost before stage two");
endmodule

// File: tb/test_blk_activity_gate.sv
`timescale 1ns/1ps
module test_blk_activity_gate;
   localparam int PW = 8;
   localparam int TP = 4;
   localparam int SD = 4;
   localparam int NP = SD * TP;
   localparam int TW = 13;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic [NP*PW-1:0] inner_px = '0;
   logic [NP*PW-1:0] outer_px = '0;
   logic             lam_we = 1'b0;
   logic [TW-1:0]    lam_wdata = '0;
   logic             out_valid;
   logic             gate;
   logic [TW-1:0]    activity;

   always #2 clk = ~clk;

   blk_activity_gate i_blk_activity_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .inner_px  (inner_px),
      .outer_px  (outer_px),
      .lam_we    (lam_we),
      .lam_wdata (lam_wdata),
      .out_valid (out_valid),
      .gate      (gate),
      .activity  (activity)
   );

   int    checks = 0;
   int    fails = 0;
   int    cyc = 0;
   bit    done = 1'b0;
   int    exp_act = 0;
   int    exp_gate = 0;
   int    model_lam = 64;
   int    q_due[$];
   int    q_act[$];
   int    q_gate[$];
   int    inn[NP];
   int    fac[NP];
   string tag = "R6";

   // behavioural score: per edge |sum(near - facing)|, then add edges
   function automatic int calc_total();
      int tot = 0;
      for (int s = 0; s < SD; s++) begin
         int acc = 0;
         for (int j = 0; j < TP; j++) begin
            acc += inn[s*TP+j] - fac[s*TP+j];
         end
         tot += (acc < 0) ? -acc : acc;
      end
      return tot;
   endfunction

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic fill(input int vi, input int vo);
      for (int i = 0; i < NP; i++) begin
         inn[i] = vi;
         fac[i] = vo;
      end
   endtask

   task automatic step(input bit v, input bit we, input int wd);
      int ev;
      int t;
      @(negedge clk);
      ev = 0;
      if (q_due.size() > 0 && q_due[0] == cyc) begin
         ev = 1;
         exp_act  = q_act.pop_front();
         exp_gate = q_gate.pop_front();
         void'(q_due.pop_front());
      end
      check(tag, "out_valid", int'(out_valid), ev);
      check(tag, "gate", int'(gate), exp_gate);
      check(tag, "activity", int'(activity), exp_act);
      for (int i = 0; i < NP; i++) begin
         inner_px[i*PW +: PW] = PW'(inn[i]);
         outer_px[i*PW +: PW] = PW'(fac[i]);
      end
      in_valid  = v;
      lam_we    = we;
      lam_wdata = TW'(wd);
      if (v) begin
         t = calc_total();
         q_due.push_back(cyc + 2);
         q_act.push_back(t);
         q_gate.push_back((t >= model_lam) ? 1 : 0);
      end
      if (we) model_lam = wd;
      cyc++;
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         fails++;
         $display("FAIL R4 watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      fill(0, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R6: reset outputs and default threshold 64
      tag = "R6";
      step(0, 0, 0);
      step(0, 0, 0);

      // R1: uniform +5 step on the upper edge -> 20, below 64
      tag = "R1";
      fill(100, 100);
      for (int j = 0; j < TP; j++) inn[j] = 105;
      step(1, 0, 0);
      // R1: alternating signs on the lower edge cancel to 0
      fill(100, 100);
      inn[4] = 150; inn[5] = 50; inn[6] = 150; inn[7] = 50;
      step(1, 0, 0);
      // R1: uniform -20 step on the left edge -> 80, gate 1
      fill(100, 100);
      for (int j = 0; j < TP; j++) inn[8+j] = 80;
      step(1, 0, 0);

      // R2: offsets +3, -7, +11, -2 -> 12+28+44+8 = 92
      tag = "R2";
      fill(120, 120);
      for (int j = 0; j < TP; j++) begin
         inn[j]    = 123;
         inn[4+j]  = 113;
         inn[8+j]  = 131;
         inn[12+j] = 118;
      end
      step(1, 0, 0);
      step(0, 0, 0);
      step(0, 0, 0);

      // R3: threshold equal to the total gives 1, one above gives 0
      tag = "R3";
      step(0, 1, 92);
      step(1, 0, 0);
      step(0, 1, 93);
      step(1, 0, 0);
      step(0, 0, 0);
      step(0, 0, 0);

      // R5: write in the same cycle as an input uses the old threshold (93)
      tag = "R5";
      step(1, 1, 0);
      step(1, 0, 0);
      step(0, 0, 0);
      step(0, 0, 0);

      // R7: pixels without valid are ignored, outputs hold
      tag = "R7";
      for (int k = 0; k < 4; k++) begin
         for (int i = 0; i < NP; i++) begin
            inn[i] = $urandom_range(255);
            fac[i] = $urandom_range(255);
         end
         step(0, 0, 0);
      end

      // R8: full scale in both directions
      tag = "R8";
      step(0, 1, 4080);
      fill(255, 0);
      step(1, 0, 0);
      fill(0, 255);
      step(1, 1, 4081);
      step(1, 0, 0);
      step(0, 0, 0);
      step(0, 0, 0);

      // R4: back-to-back stream with occasional threshold changes
      tag = "R4";
      for (int k = 0; k < 60; k++) begin
         int base;
         base = $urandom_range(200, 30);
         for (int i = 0; i < NP; i++) begin
            inn[i] = base + $urandom_range(50) - 25;
            fac[i] = base + $urandom_range(50) - 25;
         end
         if (k % 7 == 3) step(1, 1, $urandom_range(150));
         else            step(1, 0, 0);
      end
      step(0, 0, 0);
      step(0, 0, 0);
      step(0, 0, 0);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule